// File: doc/BRIEF.md
# CAN Controller Interrupt Router

This block gathers every interrupt-worthy event of a 32-mailbox CAN controller and steers it onto one of two CPU interrupt lines. There are three kinds of source. System events such as error-state changes, wake-up, denied mailbox writes, aborts and timestamp wrap all move to one line together, under a single global level bit. Per-mailbox completion and per-mailbox timeout each follow that mailbox's own bit in a level register. Each line has a flag register that software reads to find the cause. The line stays high while any flag in its register is pending.

Flags clear in one of two ways. Flags that record an edge-type event are cleared by writing 1 to them. Flags that mirror a status condition held elsewhere clear only when that condition goes away: receive overrun, abort, timeout and mailbox completion. The completion status is held inside the block as a per-mailbox pending vector. Software clears a bit of it by writing 1. Each flag register also carries the number of the lowest-numbered mailbox with an enabled completion routed to that line.

A small register port gives access. A write takes effect on the next clock edge, and reads are combinational from the addressed register.

Top module: `canirq_router`

## Requirements
- R1: After reset, every readable register reads 0 and both interrupt lines are low.
- R2: The error-passive, bus-off, wake-up and write-denied strobes each set a flag bit one cycle later: bit 1, bit 2, bit 4 and bit 5 in that order. The flag goes into the flag register of line 0 when global control bit 2 is 0, and of line 1 when it is 1.
- R3: The warning flag (bit 0) sets in the cycle after the condition "transmit count >= 96 or receive count >= 96" becomes true. It does not set again while that condition stays true.
- R4: The timestamp flag (bit 7) sets in the cycle after the timestamp MSB input goes from 0 to 1. A steady high MSB sets nothing.
- R5: A register write of 1 to flag bits 0, 1, 2, 4, 5 or 7 of a flag register (address 3 for line 0, address 4 for line 1) clears those bits. Writing 0 has no effect. Writes to bits 3, 6, 8 and 9 have no effect.
- R6: When a flag set and a clear of the same flag, or of the same mailbox pending bit, fall in one cycle, the flag or bit stays set.
- R7: The overrun flag (bit 3) on the routed line equals the OR of the overrun status vector one cycle earlier, and it is kept at 0 while global control bit 11 is 0. The abort flag (bit 6) on the routed line equals the OR of the abort status vector one cycle earlier.
- R8: The timeout flag (bit 9) of line L is 1 when, one cycle earlier, some timeout status bit was set for a mailbox whose level bit equals L.
- R9: A transmit-done or receive-done strobe for mailbox i sets bit i of the pending register (address 5), and writing 1 to that bit clears it. Bit 8 of flag register L is 1 while some pending mailbox has mask bit 1 and level bit L.
- R10: Bits 20:16 of flag register L hold the lowest mailbox number that is pending, enabled by its mask bit, and routed to L. They hold 0 when there is none.
- R11: Line L is high exactly when global control bit L is 1 and any of bits 9:0 of flag register L is 1.
- R12: The mailbox level register is at address 0 and the mailbox mask register at address 1; both are 32 bits, read/write. The global control register is at address 2 and keeps only bits 0, 1, 2 and 11, with every other bit reading 0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| tx_err_cnt | input | 8 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| ev_epass | input | 1 | Entered error-passive strobe |
| ev_busoff | input | 1 | Entered bus-off strobe |
| ev_wake | input | 1 | Left low-power mode strobe |
| ev_wdeny | input | 1 | Mailbox write denied strobe |
| ts_msb | input | 1 | Timestamp counter most significant bit |
| ovr_stat | input | 32 | Per-mailbox receive overrun status |
| abort_stat | input | 32 | Per-mailbox abort acknowledge status |
| tmo_stat | input | 32 | Per-mailbox timeout status |
| tx_done | input | 32 | Per-mailbox transmit completion strobes |
| rx_done | input | 32 | Per-mailbox receive completion strobes |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
Every stored effect of an input is due at the first clock edge after it is applied. This covers flag sets and clears, pending bits, configuration writes and the registered status flags. The interrupt lines and the completion flag and index follow in that same cycle, with no extra delay. The bench therefore updates its expected state at each edge from the inputs that were applied. It samples one nanosecond later and reads all eight addresses and both lines before the next stimulus is driven. Strobes are dropped right after the edge, so each one lasts exactly one cycle.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        RA_MBX_LVL = 3'd0,
        RA_MBX_MSK = 3'd1,
        RA_GCTRL   = 3'd2,
        RA_FLAG0   = 3'd3,
        RA_FLAG1   = 3'd4,
        RA_CPEND   = 3'd5
    } reg_addr_e;

    // flag word bits 7:0, bit 0 first from the bottom
    typedef struct packed {
        logic tsovf;   // 7
        logic abort;   // 6
        logic wdeny;   // 5
        logic wake;    // 4
        logic ovr;     // 3
        logic busoff;  // 2
        logic epass;   // 1
        logic warn;    // 0
    } sys_flags_t;

    // edge-type flags: set by an event, cleared by writing 1
    localparam logic [7:0] EDGE_MASK = 8'b1011_0111;

    localparam int FLAG_W    = 10;
    localparam int FB_IDX_LO = 16;

    localparam int GC_EN0   = 0;
    localparam int GC_EN1   = 1;
    localparam int GC_GLVL  = 2;
    localparam int GC_OVREN = 11;

endpackage

// File: rtl/canirq_cfg.sv
module canirq_cfg
    import canirq_pkg::*;
#(
    parameter int NMBX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NMBX-1:0]   lvl_o,
    output logic [NMBX-1:0]   mask_o,
    output logic              en0_o,
    output logic              en1_o,
    output logic              glvl_o,
    output logic              ovren_o
);

    typedef struct packed {
        logic [NMBX-1:0] lvl;
        logic [NMBX-1:0] mask;
        logic            en0;
        logic            en1;
        logic            glvl;
        logic            ovren;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                RA_MBX_LVL: st_d.lvl  = wdata_i[NMBX-1:0];
                RA_MBX_MSK: st_d.mask = wdata_i[NMBX-1:0];
                RA_GCTRL: begin
                    st_d.en0   = wdata_i[GC_EN0];
                    st_d.en1   = wdata_i[GC_EN1];
                    st_d.glvl  = wdata_i[GC_GLVL];
                    st_d.ovren = wdata_i[GC_OVREN];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o   = st_q.lvl;
    assign mask_o  = st_q.mask;
    assign en0_o   = st_q.en0;
    assign en1_o   = st_q.en1;
    assign glvl_o  = st_q.glvl;
    assign ovren_o = st_q.ovren;

    // R12: a write to the level register lands on the next edge
    a_r12_lvl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_MBX_LVL) |=> (lvl_o == $past(wdata_i[NMBX-1:0])));

endmodule

// File: rtl/canirq_src.sv
module canirq_src
    import canirq_pkg::*;
#(
    parameter int NMBX     = 32,
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_err_i,
    input  logic [CNT_W-1:0] rx_err_i,
    input  logic             epass_i,
    input  logic             busoff_i,
    input  logic             wake_i,
    input  logic             wdeny_i,
    input  logic             ts_msb_i,
    input  logic [NMBX-1:0]  tx_done_i,
    input  logic [NMBX-1:0]  rx_done_i,
    input  logic [NMBX-1:0]  pclr_i,
    output sys_flags_t       sys_set_o,
    output logic [NMBX-1:0]  pend_o
);

    typedef struct packed {
        logic            warn_prev;
        logic            ts_prev;
        logic [NMBX-1:0] pend;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    warn_now;
    logic [NMBX-1:0] done_w;

    always_comb begin
        warn_now = (tx_err_i >= CNT_W'(WARN_LIM)) || (rx_err_i >= CNT_W'(WARN_LIM));
        done_w   = tx_done_i | rx_done_i;

        sys_set_o        = '0;
        sys_set_o.warn   = warn_now & ~st_q.warn_prev;
        sys_set_o.epass  = epass_i;
        sys_set_o.busoff = busoff_i;
        sys_set_o.wake   = wake_i;
        sys_set_o.wdeny  = wdeny_i;
        sys_set_o.tsovf  = ts_msb_i & ~st_q.ts_prev;

        st_d.warn_prev = warn_now;
        st_d.ts_prev   = ts_msb_i;
        // a new completion overrides a clear of the same bit
        st_d.pend      = (st_q.pend & ~pclr_i) | done_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R9 / R6: a completion strobe always leaves its pending bit set
    a_r9_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_w) |=> ((pend_o & $past(done_w)) == $past(done_w)));

    // R9: a clear with no new completion removes the bit
    a_r9_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pclr_i & ~done_w)) |=> ((pend_o & $past(pclr_i & ~done_w)) == '0));

endmodule

// File: rtl/canirq_lowidx.sv
module canirq_lowidx #(
    parameter int NW = 32,
    parameter int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    // R10: reported index is set and nothing below it is set
    a_r10_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (vec_i[idx_o] && ((vec_i & ((NW'(1) << idx_o) - NW'(1))) == '0)));

endmodule

// File: rtl/canirq_line.sv
module canirq_line
    import canirq_pkg::*;
#(
    parameter int NMBX = 32,
    parameter bit LINE = 1'b0,
    localparam int IDX_W = $clog2(NMBX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              glvl_i,
    input  logic              ovren_i,
    input  sys_flags_t        sys_set_i,
    input  logic [NMBX-1:0]   ovr_stat_i,
    input  logic [NMBX-1:0]   abort_stat_i,
    input  logic [NMBX-1:0]   tmo_stat_i,
    input  logic [NMBX-1:0]   lvl_i,
    input  logic [NMBX-1:0]   mask_i,
    input  logic [NMBX-1:0]   pend_i,
    input  logic              fwr_i,
    input  logic [7:0]        fwdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [7:0] edg_f;
        logic       ovr;
        logic       abort;
        logic       tmo;
    } line_st_t;

    line_st_t        st_d, st_q;
    logic            mine;
    logic [NMBX-1:0] sel;
    logic [NMBX-1:0] cmpl_vec;
    logic [7:0]      set_w;
    logic [7:0]      clr_w;
    logic            cmpl_any;

    always_comb begin
        mine     = (glvl_i == LINE);
        sel      = LINE ? lvl_i : ~lvl_i;
        set_w    = mine ? (sys_set_i & EDGE_MASK) : 8'h00;
        clr_w    = fwr_i ? (fwdata_i & EDGE_MASK) : 8'h00;
        cmpl_vec = pend_i & mask_i & sel;

        st_d.edg_f = (st_q.edg_f & ~clr_w) | set_w;
        st_d.ovr   = mine & ovren_i & (|ovr_stat_i);
        st_d.abort = mine & (|abort_stat_i);
        st_d.tmo   = |(tmo_stat_i & sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    canirq_lowidx #(
        .NW (NMBX),
        .IW (IDX_W)
    ) i_lowidx (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec_i   (cmpl_vec),
        .found_o (cmpl_any),
        .idx_o   (idx_o)
    );

    always_comb begin
        flags_o      = '0;
        flags_o[7:0] = st_q.edg_f;
        flags_o[3]   = st_q.ovr;
        flags_o[6]   = st_q.abort;
        flags_o[8]   = cmpl_any;
        flags_o[9]   = st_q.tmo;
    end

    assign irq_o = en_i & (|flags_o);

    // R5: a write-one clear with no competing set empties the flag
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_w & ~set_w)) |=> ((flags_o[7:0] & $past(clr_w & ~set_w) & EDGE_MASK) == '0));

    // R6: set wins over a same-cycle clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_w) |=> ((flags_o[7:0] & $past(set_w)) == $past(set_w)));

    // R11: a disabled line never asserts
    a_r11_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o);

endmodule

// File: rtl/canirq_router.sv
module canirq_router
    import canirq_pkg::*;
#(
    parameter int NMBX     = 32,
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic              ev_epass,
    input  logic              ev_busoff,
    input  logic              ev_wake,
    input  logic              ev_wdeny,
    input  logic              ts_msb,
    input  logic [NMBX-1:0]   ovr_stat,
    input  logic [NMBX-1:0]   abort_stat,
    input  logic [NMBX-1:0]   tmo_stat,
    input  logic [NMBX-1:0]   tx_done,
    input  logic [NMBX-1:0]   rx_done,
    output logic              irq0,
    output logic              irq1
);

    localparam int IDX_W = $clog2(NMBX);

    logic [NMBX-1:0]   lvl_w, mask_w, pend_w, pclr_w;
    logic              en0_w, en1_w, glvl_w, ovren_w;
    sys_flags_t        sys_set_w;
    logic [1:0]        en_w, irq_w, fwr_w;
    logic [FLAG_W-1:0] flg_w [2];
    logic [IDX_W-1:0]  idx_w [2];

    canirq_cfg #(.NMBX(NMBX)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .lvl_o   (lvl_w),
        .mask_o  (mask_w),
        .en0_o   (en0_w),
        .en1_o   (en1_w),
        .glvl_o  (glvl_w),
        .ovren_o (ovren_w)
    );

    assign pclr_w = (reg_wr && reg_addr == RA_CPEND) ? reg_wdata[NMBX-1:0] : '0;

    canirq_src #(
        .NMBX     (NMBX),
        .CNT_W    (CNT_W),
        .WARN_LIM (WARN_LIM)
    ) i_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_err_i  (tx_err_cnt),
        .rx_err_i  (rx_err_cnt),
        .epass_i   (ev_epass),
        .busoff_i  (ev_busoff),
        .wake_i    (ev_wake),
        .wdeny_i   (ev_wdeny),
        .ts_msb_i  (ts_msb),
        .tx_done_i (tx_done),
        .rx_done_i (rx_done),
        .pclr_i    (pclr_w),
        .sys_set_o (sys_set_w),
        .pend_o    (pend_w)
    );

    assign en_w = {en1_w, en0_w};

    for (genvar g = 0; g < 2; g++) begin : g_line
        assign fwr_w[g] = reg_wr && (reg_addr == ADDR_W'(RA_FLAG0 + g));

        canirq_line #(
            .NMBX (NMBX),
            .LINE (1'(g))
        ) i_line (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (en_w[g]),
            .glvl_i       (glvl_w),
            .ovren_i      (ovren_w),
            .sys_set_i    (sys_set_w),
            .ovr_stat_i   (ovr_stat),
            .abort_stat_i (abort_stat),
            .tmo_stat_i   (tmo_stat),
            .lvl_i        (lvl_w),
            .mask_i       (mask_w),
            .pend_i       (pend_w),
            .fwr_i        (fwr_w[g]),
            .fwdata_i     (reg_wdata[7:0]),
            .flags_o      (flg_w[g]),
            .idx_o        (idx_w[g]),
            .irq_o        (irq_w[g])
        );
    end

    assign irq0 = irq_w[0];
    assign irq1 = irq_w[1];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MBX_LVL: reg_rdata[NMBX-1:0] = lvl_w;
            RA_MBX_MSK: reg_rdata[NMBX-1:0] = mask_w;
            RA_GCTRL: begin
                reg_rdata[GC_EN0]   = en0_w;
                reg_rdata[GC_EN1]   = en1_w;
                reg_rdata[GC_GLVL]  = glvl_w;
                reg_rdata[GC_OVREN] = ovren_w;
            end
            RA_FLAG0: begin
                reg_rdata[FLAG_W-1:0]           = flg_w[0];
                reg_rdata[FB_IDX_LO +: IDX_W]   = idx_w[0];
            end
            RA_FLAG1: begin
                reg_rdata[FLAG_W-1:0]           = flg_w[1];
                reg_rdata[FB_IDX_LO +: IDX_W]   = idx_w[1];
            end
            RA_CPEND: reg_rdata[NMBX-1:0] = pend_w;
            default: ;
        endcase
    end

    // R12: unmapped addresses read as zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(RA_CPEND)) |-> (reg_rdata == '0));

    // R2: a system strobe lands in the flag register chosen by the global level
    a_r2_route_busoff: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busoff |=> flg_w[$past(glvl_w)][2]);

endmodule

// File: tb/test_canirq_router.sv
`timescale 1ns/100ps
module test_canirq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
    logic        ev_epass = 0, ev_busoff = 0, ev_wake = 0, ev_wdeny = 0, ts_msb = 0;
    logic [31:0] ovr_stat = '0, abort_stat = '0, tmo_stat = '0, tx_done = '0, rx_done = '0;
    logic        irq0, irq1;

    always #4 clk = ~clk;

    canirq_router i_canirq_router (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .ev_epass(ev_epass), .ev_busoff(ev_busoff), .ev_wake(ev_wake),
        .ev_wdeny(ev_wdeny), .ts_msb(ts_msb), .ovr_stat(ovr_stat),
        .abort_stat(abort_stat), .tmo_stat(tmo_stat), .tx_done(tx_done),
        .rx_done(rx_done), .irq0(irq0), .irq1(irq1)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected state
    logic [31:0] m_lvl = '0, m_mask = '0, m_gc = '0, m_pend = '0;
    logic [7:0]  m_edge [2] = '{8'h00, 8'h00};
    logic        m_ovr [2] = '{1'b0, 1'b0};
    logic        m_ab  [2] = '{1'b0, 1'b0};
    logic        m_tmo [2] = '{1'b0, 1'b0};
    logic        m_wprev = 0, m_tprev = 0;

    function automatic logic [31:0] exp_flags(int l);
        logic [31:0] sel, v, f;
        logic [4:0]  idx;
        sel = (l == 1) ? m_lvl : ~m_lvl;
        v   = m_pend & m_mask & sel;
        idx = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) idx = 5'(i);
        f        = '0;
        f[7:0]   = m_edge[l];
        f[3]     = m_ovr[l];
        f[6]     = m_ab[l];
        f[8]     = |v;
        f[9]     = m_tmo[l];
        f[20:16] = idx;
        return f;
    endfunction

    function automatic logic exp_irq(int l);
        logic [31:0] f;
        f = exp_flags(l);
        return m_gc[l] & (|f[9:0]);
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return m_lvl;
            3'd1: return m_mask;
            3'd2: return m_gc;
            3'd3: return exp_flags(0);
            3'd4: return exp_flags(1);
            3'd5: return m_pend;
            default: return '0;
        endcase
    endfunction

    task automatic model_step();
        logic [7:0]  sset, clr;
        logic        wn, gl;
        logic [31:0] sel;
        wn   = (tx_err_cnt >= 8'd96) || (rx_err_cnt >= 8'd96);
        sset = {ts_msb & ~m_tprev, 1'b0, ev_wdeny, ev_wake, 1'b0, ev_busoff, ev_epass, wn & ~m_wprev};
        gl   = m_gc[2];
        for (int l = 0; l < 2; l++) begin
            clr = (reg_wr && reg_addr == 3'(3 + l)) ? (reg_wdata[7:0] & 8'hB7) : 8'h00;
            m_edge[l] = (m_edge[l] & ~clr) | ((gl == l[0]) ? sset : 8'h00);
            m_ovr[l]  = (gl == l[0]) & m_gc[11] & (|ovr_stat);
            m_ab[l]   = (gl == l[0]) & (|abort_stat);
            sel       = (l == 1) ? m_lvl : ~m_lvl;
            m_tmo[l]  = |(tmo_stat & sel);
        end
        m_pend = (m_pend & ~((reg_wr && reg_addr == 3'd5) ? reg_wdata : 32'h0)) | tx_done | rx_done;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_lvl  = reg_wdata;
                3'd1: m_mask = reg_wdata;
                3'd2: m_gc   = reg_wdata & 32'h0000_0807;
                default: ;
            endcase
        end
        m_wprev = wn;
        m_tprev = ts_msb;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (addr %0d) at %0t", tag, act, exp, reg_addr, $time);
        end
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #0.5;
            chk(tag, reg_rdata, exp_read(3'(a)));
        end
        chk(tag, {31'b0, irq0}, {31'b0, exp_irq(0)});
        chk(tag, {31'b0, irq1}, {31'b0, exp_irq(1)});
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        #1;
        reg_wr = 0; ev_epass = 0; ev_busoff = 0; ev_wake = 0; ev_wdeny = 0;
        tx_done = '0; rx_done = '0;
        sweep(tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1 sweep("R1 reset state");

        // R12 register map
        wr(3'd0, 32'hF0F0_00FF); tick("R12 level reg");
        wr(3'd1, 32'hFFFF_FFFF); tick("R12 mask reg");
        wr(3'd2, 32'hFFFF_FFFF); tick("R12 gctrl keeps bits 0,1,2,11");
        wr(3'd2, 32'h0000_0803); tick("R12 gctrl");

        // R2 routing of system strobes
        ev_epass = 1; tick("R2 epass to line 0");
        wr(3'd2, 32'h0000_0807); tick("R2 level to 1");
        ev_busoff = 1; tick("R2 busoff to line 1");
        ev_wdeny = 1; tick("R2 wdeny to line 1");

        // R3 warning threshold
        tx_err_cnt = 8'd95; tick("R3 below limit");
        tx_err_cnt = 8'd96; tick("R3 at limit");
        wr(3'd4, 32'h0000_00FF); tick("R5 clear line 1");
        rx_err_cnt = 8'd200; tick("R3 stays high no reset");
        tx_err_cnt = 0; rx_err_cnt = 0; tick("R3 drop");

        // R4 timestamp edge
        ts_msb = 1; tick("R4 rise");
        wr(3'd4, 32'h0000_0080); tick("R4 clear while high");
        tick("R4 steady high no set");
        ts_msb = 0; tick("R4 fall");

        // R7 status-derived flags
        ovr_stat = 32'h1; abort_stat = 32'h2; tick("R7 ovr abort set");
        wr(3'd4, 32'hFFFF_FFFF); tick("R5 write cannot clear status flags");
        ovr_stat = 0; tick("R7 ovr cleared");
        abort_stat = 0; tick("R7 abort cleared");
        wr(3'd2, 32'h0000_0007); tick("R7 ovr disable");
        ovr_stat = 32'h4; tick("R7 ovr disabled");
        ovr_stat = 0; wr(3'd2, 32'h0000_0807); tick("R7 restore");

        // R6 set beats clear
        ev_wake = 1; tick("R6 wake set");
        ev_wake = 1; wr(3'd4, 32'h0000_0010); tick("R6 set wins");
        wr(3'd4, 32'h0000_0010); tick("R5 clear wake");
        wr(3'd4, 32'h0000_0000); tick("R5 write zero no effect");

        // R8 timeouts
        tmo_stat = 32'h0000_0100; tick("R8 line 0 timeout");
        tmo_stat = 32'h8000_0000; tick("R8 line 1 timeout");
        tmo_stat = 0; tick("R8 cleared");

        // R9 / R10 completions
        tx_done = 32'h0000_0600; tick("R9 tx done");
        rx_done = 32'h0000_0001; tick("R10 rx done line 1");
        wr(3'd5, 32'h0000_0200); tick("R10 index moves up");
        wr(3'd1, 32'hFFFF_FBFF); tick("R9 mask hides");
        tx_done = 32'h1; wr(3'd5, 32'h0000_0001); tick("R6 pending set wins");
        wr(3'd5, 32'hFFFF_FFFF); tick("R9 clear all");

        // R11 line enables
        ev_epass = 1; wr(3'd2, 32'h0000_0004); tick("R11 lines disabled");
        wr(3'd2, 32'h0000_0807); tick("R11 enabled");
        wr(3'd4, 32'hFFFF_FFFF); tick("R11 released");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) tx_err_cnt = 8'($urandom_range(85, 105));
            if ($urandom_range(0, 3) == 0) rx_err_cnt = 8'($urandom_range(85, 105));
            ev_epass  = ($urandom_range(0, 7) == 0);
            ev_busoff = ($urandom_range(0, 7) == 0);
            ev_wake   = ($urandom_range(0, 7) == 0);
            ev_wdeny  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) ts_msb = ~ts_msb;
            if ($urandom_range(0, 7) == 0) ovr_stat   = $urandom & $urandom & $urandom;
            if ($urandom_range(0, 7) == 0) abort_stat = $urandom & $urandom & $urandom;
            if ($urandom_range(0, 7) == 0) tmo_stat   = $urandom & $urandom & $urandom;
            if ($urandom_range(0, 3) == 0) tx_done = 32'h1 << $urandom_range(0, 31);
            if ($urandom_range(0, 3) == 0) rx_done = 32'h1 << $urandom_range(0, 31);
            if ($urandom_range(0, 2) == 0) wr(3'($urandom_range(0, 7)), $urandom);
            tick("random R2 R9 R11 mix");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule